// File: doc/BRIEF.md
# Exception Priority Mask Gate

This block decides whether a pending exception may be taken now. It holds three mask registers: a one-bit global mask, a one-bit fault mask and a priority-threshold register. These combine with the processor's current execution priority into one effective priority level. A pending exception is taken only when its priority is numerically lower, and therefore more urgent, than that level. The fault mask raises the level to -1, so it also blocks the fixed-priority hard fault. The non-maskable interrupt (-2) and reset (-3) sit below every mask and are not blocked by them.

Software changes the masks in two ways. Each register has its own write strobe. Separately, an interrupt-enable request clears the global mask and an interrupt-disable request sets it. The arbiter that picks the pending exception and the vector fetch are outside this block. The gate gets one candidate each cycle and returns a registered take flag together with the registered effective priority.

Top module: `exc_mask_gate`

## Requirements
- R1: After synchronous reset all three mask registers hold 0 and `take` is 0. One clock after inputs are applied, `eff_prio` equals `cur_prio`.
- R2: A pending configurable exception (`pend_cls`=0) of priority `pend_prio` is taken only when `pend_valid` is 1 and `pend_prio` is strictly less than the effective priority. Equal priority is not taken.
- R3: While the global mask is 1, the effective priority is at most 0. This blocks every configurable exception, while a hard fault (`pend_cls`=1, level -1) is still taken.
- R4: While the fault mask is 1, the effective priority is at most -1. This blocks the hard fault, while a non-maskable interrupt (`pend_cls`=2, level -2) is still taken.
- R5: A threshold value of 0 disables threshold masking. A nonzero threshold T limits the effective priority to T, which blocks configurable priorities greater than or equal to T.
- R6: The effective priority is the minimum of `cur_prio` and the levels implied by each active mask.
- R7: `dis_req` sets the global mask and `en_req` clears it.
- R8: When several requests hit the global mask in the same cycle, `dis_req` wins over `en_req`, and `en_req` wins over a register write.
- R9: `wr_gmask` and `wr_fmask` load `wr_data` bit 0 into their mask. `wr_thresh` loads all of `wr_data` into the threshold.
- R10: Reset-class (`pend_cls`=3, level -3) and non-maskable exceptions are taken whenever `cur_prio` is above their level, whatever the mask contents.
- R11: A mask change made at clock edge n first affects `eff_prio` and `take` at edge n+1. Pending and current-priority inputs sampled at edge n appear at edge n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_gmask | input | 1 | Write strobe for the global mask |
| wr_fmask | input | 1 | Write strobe for the fault mask |
| wr_thresh | input | 1 | Write strobe for the threshold register |
| wr_data | input | PW | Write data shared by the three strobes |
| en_req | input | 1 | Interrupt-enable request (clears global mask) |
| dis_req | input | 1 | Interrupt-disable request (sets global mask) |
| pend_valid | input | 1 | A candidate exception is pending |
| pend_cls | input | 2 | 0 configurable, 1 hard fault, 2 non-maskable, 3 reset |
| pend_prio | input | PW | Priority of a configurable candidate |
| cur_prio | input | PW+2 | Current execution priority, signed |
| take | output | 1 | Registered: candidate may be taken |
| eff_prio | output | PW+2 | Registered effective priority, signed |

## Verification
Three requests can reach the global mask in the same cycle: the enable request, the disable request and a register write. The bench drives them in pairs on one clock. It then reads the resulting mask through `eff_prio` with `cur_prio` held high, which separates 0 (mask set) from the thread level (mask clear). A second overlap lies between a mask write and a pending exception sampled at the same edge. The bench checks that the take decision at the next edge still uses the old mask, and that only the one after it sees the new one.

// File: rtl/emg_pkg.sv
package emg_pkg;
  typedef enum logic [1:0] {
    CLS_CFG   = 2'd0,
    CLS_HARD  = 2'd1,
    CLS_NMI   = 2'd2,
    CLS_RESET = 2'd3
  } exc_cls_e;
endpackage

// File: rtl/emg_mask_regs.sv
module emg_mask_regs #(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_gmask,
  input  logic          wr_fmask,
  input  logic          wr_thresh,
  input  logic [PW-1:0] wr_data,
  input  logic          en_req,
  input  logic          dis_req,
  output logic          gmask_q,
  output logic          fmask_q,
  output logic [PW-1:0] thresh_q
);
  // global mask: disable beats enable beats write
  always_ff @(posedge clk) begin
    if (rst) gmask_q <= 1'b0;
    else if (dis_req) gmask_q <= 1'b1;
    else if (en_req) gmask_q <= 1'b0;
    else if (wr_gmask) gmask_q <= wr_data[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fmask_q  <= 1'b0;
      thresh_q <= '0;
    end else begin
      if (wr_fmask)  fmask_q  <= wr_data[0];
      if (wr_thresh) thresh_q <= wr_data;
    end
  end

  assert_dis_sets_R7: assert property (@(posedge clk) disable iff (rst)
    dis_req |=> gmask_q);
  assert_en_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (en_req && !dis_req) |=> !gmask_q);
  assert_fmask_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!wr_fmask && !$past(rst)) |=> $stable(fmask_q));
endmodule

// File: rtl/emg_resolve.sv
module emg_resolve
  import emg_pkg::*;
#(
  parameter int PW = 4,
  parameter int LW = PW + 2
) (
  input  logic                 gmask,
  input  logic                 fmask,
  input  logic [PW-1:0]        thresh,
  input  logic signed [LW-1:0] cur_prio,
  input  logic                 pend_valid,
  input  exc_cls_e             pend_cls,
  input  logic [PW-1:0]        pend_prio,
  output logic signed [LW-1:0] eff,
  output logic                 take
);
  localparam int NCAND = 4;
  localparam logic signed [LW-1:0] LVL_MAX   = {1'b0, {(LW-1){1'b1}}};
  localparam logic signed [LW-1:0] LVL_ZERO  = '0;
  localparam logic signed [LW-1:0] LVL_HARD  = -1;
  localparam logic signed [LW-1:0] LVL_NMI   = -2;
  localparam logic signed [LW-1:0] LVL_RESET = -3;

  logic signed [LW-1:0] cand [NCAND];
  logic signed [LW-1:0] pend_lvl;

  always_comb begin
    cand[0] = cur_prio;
    cand[1] = gmask ? LVL_ZERO : LVL_MAX;
    cand[2] = fmask ? LVL_HARD : LVL_MAX;
    cand[3] = (thresh != '0) ? $signed({{(LW-PW){1'b0}}, thresh}) : LVL_MAX;
  end

  always_comb begin
    eff = LVL_MAX;
    for (int i = 0; i < NCAND; i++)
      if (cand[i] < eff) eff = cand[i];
  end

  always_comb begin
    unique case (pend_cls)
      CLS_CFG:   pend_lvl = $signed({{(LW-PW){1'b0}}, pend_prio});
      CLS_HARD:  pend_lvl = LVL_HARD;
      CLS_NMI:   pend_lvl = LVL_NMI;
      default:   pend_lvl = LVL_RESET;
    endcase
    take = pend_valid && (pend_lvl < eff);
  end
endmodule

// File: rtl/exc_mask_gate.sv
module exc_mask_gate
  import emg_pkg::*;
#(
  parameter int PW = 4,
  localparam int LW = PW + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_gmask,
  input  logic                 wr_fmask,
  input  logic                 wr_thresh,
  input  logic [PW-1:0]        wr_data,
  input  logic                 en_req,
  input  logic                 dis_req,
  input  logic                 pend_valid,
  input  logic [1:0]           pend_cls,
  input  logic [PW-1:0]        pend_prio,
  input  logic signed [LW-1:0] cur_prio,
  output logic                 take,
  output logic signed [LW-1:0] eff_prio
);
  logic                 gmask_q, fmask_q;
  logic [PW-1:0]        thresh_q;
  logic signed [LW-1:0] eff_c;
  logic                 take_c;

  emg_mask_regs #(.PW(PW)) u_regs (
    .clk(clk), .rst(rst),
    .wr_gmask(wr_gmask), .wr_fmask(wr_fmask), .wr_thresh(wr_thresh),
    .wr_data(wr_data), .en_req(en_req), .dis_req(dis_req),
    .gmask_q(gmask_q), .fmask_q(fmask_q), .thresh_q(thresh_q)
  );

  emg_resolve #(.PW(PW), .LW(LW)) u_res (
    .gmask(gmask_q), .fmask(fmask_q), .thresh(thresh_q),
    .cur_prio(cur_prio), .pend_valid(pend_valid),
    .pend_cls(exc_cls_e'(pend_cls)), .pend_prio(pend_prio),
    .eff(eff_c), .take(take_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take     <= 1'b0;
      eff_prio <= '0;
    end else begin
      take     <= take_c;
      eff_prio <= eff_c;
    end
  end

  assert_take_needs_valid_R2: assert property (@(posedge clk) disable iff (rst)
    (take && !$past(rst)) |-> $past(pend_valid));
  assert_gmask_level_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(gmask_q)) |-> (eff_prio <= 0));
  assert_fmask_level_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fmask_q)) |-> (eff_prio <= -1));
  assert_eff_not_above_cur_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (eff_prio <= $past(cur_prio)));
  assert_reset_unmasked_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pend_valid) && ($past(pend_cls) == 2'd3)
     && ($past(cur_prio) > -3)) |-> take);
endmodule

// File: tb/tb_exc_mask_gate.sv
module tb_exc_mask_gate;
  localparam int PW = 4;
  localparam int LW = PW + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_gmask = 0, wr_fmask = 0, wr_thresh = 0;
  logic [PW-1:0] wr_data = '0;
  logic en_req = 0, dis_req = 0;
  logic pend_valid = 0;
  logic [1:0] pend_cls = 2'd0;
  logic [PW-1:0] pend_prio = '0;
  logic signed [LW-1:0] cur_prio = 16;
  logic take;
  logic signed [LW-1:0] eff_prio;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  exc_mask_gate #(.PW(PW)) dut (
    .clk(clk), .rst(rst), .wr_gmask(wr_gmask), .wr_fmask(wr_fmask),
    .wr_thresh(wr_thresh), .wr_data(wr_data), .en_req(en_req),
    .dis_req(dis_req), .pend_valid(pend_valid), .pend_cls(pend_cls),
    .pend_prio(pend_prio), .cur_prio(cur_prio), .take(take), .eff_prio(eff_prio)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pend(input logic v, input logic [1:0] c, input int p, input int cur);
    pend_valid = v; pend_cls = c; pend_prio = PW'(p); cur_prio = LW'(cur);
    settle();
  endtask

  task automatic wr(input logic g, input logic f, input logic t, input int d);
    @(negedge clk);
    wr_gmask = g; wr_fmask = f; wr_thresh = t; wr_data = PW'(d);
    @(negedge clk);
    wr_gmask = 0; wr_fmask = 0; wr_thresh = 0;
    @(negedge clk);
  endtask

  task automatic reqs(input logic e, input logic d, input logic g, input int wd);
    @(negedge clk);
    en_req = e; dis_req = d; wr_gmask = g; wr_data = PW'(wd);
    @(negedge clk);
    en_req = 0; dis_req = 0; wr_gmask = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    pend(0, 0, 0, 16);
    check("R1 eff after reset", int'(eff_prio), 16);
    check("R1 take after reset", int'(take), 0);
  endtask

  task automatic t_plain();
    pend(1, 0, 5, 16); check("R2 prio5 cur16", int'(take), 1);
    pend(1, 0, 5, 5);  check("R2 equal prio", int'(take), 0);
    pend(1, 0, 5, 6);  check("R2 prio5 cur6", int'(take), 1);
    pend(0, 0, 5, 16); check("R2 not valid", int'(take), 0);
  endtask

  task automatic t_global();
    reqs(0, 1, 0, 0);
    pend(1, 0, 0, 16);
    check("R7 disable sets gmask", int'(eff_prio), 0);
    check("R3 cfg prio0 blocked", int'(take), 0);
    pend(1, 1, 0, 16); check("R3 hard fault taken", int'(take), 1);
    reqs(1, 0, 0, 0);
    pend(1, 0, 0, 16);
    check("R7 enable clears gmask", int'(eff_prio), 16);
    check("R7 cfg taken again", int'(take), 1);
  endtask

  task automatic t_fault();
    wr(0, 1, 0, 1);
    pend(1, 1, 0, 16);
    check("R9 fmask write", int'(eff_prio), -1);
    check("R4 hard fault blocked", int'(take), 0);
    pend(1, 2, 0, 16); check("R10 nmi taken", int'(take), 1);
    pend(1, 3, 0, 16); check("R10 reset taken", int'(take), 1);
    wr(0, 1, 0, 0);
    pend(1, 1, 0, 16); check("R9 fmask cleared", int'(take), 1);
  endtask

  task automatic t_thresh();
    wr(0, 0, 1, 4);
    pend(1, 0, 3, 16);
    check("R5 eff at thresh", int'(eff_prio), 4);
    check("R5 prio3 taken", int'(take), 1);
    pend(1, 0, 4, 16); check("R5 prio4 blocked", int'(take), 0);
    pend(1, 0, 4, 2);  check("R6 cur below thresh", int'(eff_prio), 2);
    wr(0, 0, 1, 0);
    pend(1, 0, 15, 16);
    check("R5 zero disables", int'(eff_prio), 16);
    check("R5 prio15 taken", int'(take), 1);
  endtask

  task automatic t_combo();
    wr(1, 1, 1, 9);
    pend(1, 2, 0, 16);
    check("R6 min of all masks", int'(eff_prio), -1);
    check("R10 nmi through all masks", int'(take), 1);
    pend(1, 3, 0, -2); check("R10 reset under nmi handler", int'(take), 1);
    pend(1, 2, 0, -2); check("R2 nmi at nmi level", int'(take), 0);
    wr(1, 1, 1, 0);
    pend(0, 0, 0, 16);
    check("R9 all cleared", int'(eff_prio), 16);
  endtask

  task automatic t_conflict();
    reqs(1, 1, 0, 0);
    pend(0, 0, 0, 16); check("R8 disable beats enable", int'(eff_prio), 0);
    reqs(1, 0, 1, 1);
    pend(0, 0, 0, 16); check("R8 enable beats write", int'(eff_prio), 16);
    reqs(0, 1, 1, 0);
    pend(0, 0, 0, 16); check("R8 disable beats write", int'(eff_prio), 0);
    reqs(0, 0, 1, 0);
    pend(0, 0, 0, 16); check("R9 gmask written 0", int'(eff_prio), 16);
  endtask

  task automatic t_latency();
    pend_valid = 1; pend_cls = 2'd1; cur_prio = 16;
    @(negedge clk);
    wr_fmask = 1; wr_data = 1;
    @(negedge clk);
    wr_fmask = 0;
    check("R11 old mask one edge later", int'(take), 1);
    @(negedge clk);
    check("R11 new mask second edge", int'(take), 0);
    check("R11 eff second edge", int'(eff_prio), -1);
    wr(0, 1, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_plain();
    t_global();
    t_fault();
    t_thresh();
    t_combo();
    t_conflict();
    t_latency();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule